// File: doc/BRIEF.md
# Ramped Stereo Volume Stage

This block scales a stereo stream of 24-bit two's-complement samples by a programmable gain. Software or a control decoder supplies an 11-bit target code. The block never jumps to that code. It keeps its own current gain code and moves it by one unit toward the target on every output-sample strobe, so a change in volume becomes a ramp rather than a click.

The gain is linear in the code. In normal mode the gain is code/1024, so 400H is unity. When the boost input is set, the gain becomes code/256. In that mode 100H is unity and 400H is roughly +12 dB, and any result that leaves the 24-bit range is clipped. Codes above 400H are treated as 400H. Code 000H silences both channels.

Both channels share one gain value. Each sample strobe registers the two scaled outputs using the gain code shown on `gain_code` before that strobe. On the same edge the gain code takes its step.

Top module: `gain_ramp_stage`

## Requirements
- R1: After reset, `gain_code` reads 400H, both outputs read zero, and boost is off.
- R2: A target code in the range 401H to 7FFH behaves exactly like 400H. The gain ramps to 400H and stops there.
- R3: In normal mode, a strobe registers `dout = floor(din * g / 1024)` for each channel, where g is the gain code before the strobe. The result is an arithmetic shift right by 10, so it rounds toward minus infinity.
- R4: With gain code 000H the outputs are zero, in both normal mode and boost mode.
- R5: In boost mode the result is `floor(din * g / 256)`, clipped to 7FFFFFH when positive and to 800000H when negative.
- R6: On each strobe the gain code moves by exactly one toward the registered target. It holds when it already equals the target. Without a strobe it never changes. The target and boost inputs are registered one clock before use.
- R7: A new target that arrives in the middle of a ramp redirects the ramp from the present gain code. The ramp does not restart.
- R8: Both channels are scaled by the same gain code within one strobe.
- R9: A sweep from 400H down to 000H takes exactly 1024 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Output-sample strobe, one clock wide |
| din_l | input | 24 | Left input sample, two's complement |
| din_r | input | 24 | Right input sample, two's complement |
| tgt_code | input | 11 | Target gain code |
| boost_en | input | 1 | Selects the x4 (+12 dB) scaling |
| dout_l | output | 24 | Scaled left sample |
| dout_r | output | 24 | Scaled right sample |
| gain_code | output | 11 | Current gain code |

## Verification
The bench builds the block with its default parameters: 24-bit data, 11-bit codes, and shifts of 10 and 8. With these values the full 1024-step sweep and the 400H ceiling can be reached in a short run. The 8-bit boost shift lets a mid-scale input drive the clip limits in both directions. Odd negative inputs at half gain exercise the rounding toward minus infinity. A mid-ramp change of target exercises the redirection of the ramp.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_UP   = 2'd1,
      RAMP_DOWN = 2'd2
   } ramp_dir_e;
endpackage

// File: rtl/grs_target_reg.sv
module grs_target_reg #(
   parameter int GW    = 11,
   parameter int UNITY = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] code_in,
   input  logic          boost_in,
   output logic [GW-1:0] tgt_q,
   output logic          boost_q
);
   localparam logic [GW-1:0] UNITY_C = GW'(UNITY);

   logic [GW-1:0] code_sat;

   generate
      if (UNITY > (1 << GW) - 1) begin : g_bad
         $error("UNITY code does not fit in GW bits");
      end
      if (UNITY == (1 << GW) - 1) begin : g_nosat
         assign code_sat = code_in;
      end else begin : g_sat
         assign code_sat = (code_in > UNITY_C) ? UNITY_C : code_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q   <= UNITY_C;
         boost_q <= 1'b0;
      end else begin
         tgt_q   <= code_sat;
         boost_q <= boost_in;
      end
   end

   a_r2_target_capped: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_q <= UNITY_C);
   a_r2_large_code_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (code_in >= UNITY_C) |=> (tgt_q == UNITY_C));
endmodule

// File: rtl/grs_gain_ramp.sv
module grs_gain_ramp
   import gain_ramp_pkg::*;
#(
   parameter int GW    = 11,
   parameter int UNITY = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_en,
   input  logic [GW-1:0] tgt,
   output logic [GW-1:0] cur
);
   localparam logic [GW-1:0] UNITY_C = GW'(UNITY);
   localparam logic [GW-1:0] ONE_C   = GW'(1);

   ramp_dir_e     dir;
   logic [GW-1:0] cur_nxt;

   always_comb begin
      if (cur < tgt)      dir = RAMP_UP;
      else if (cur > tgt) dir = RAMP_DOWN;
      else                dir = RAMP_HOLD;
   end

   always_comb begin
      unique case (dir)
         RAMP_UP:   cur_nxt = cur + ONE_C;
         RAMP_DOWN: cur_nxt = cur - ONE_C;
         default:   cur_nxt = cur;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur <= UNITY_C;
      else if (step_en) cur <= cur_nxt;
   end

   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (cur == $past(cur) + ONE_C || cur == $past(cur) - ONE_C || cur == $past(cur)));
   a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(cur));
   a_r7_moves_toward_target: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && cur != tgt) |=> (cur != $past(cur)));
   a_r2_gain_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= UNITY_C);
endmodule

// File: rtl/grs_chan_scale.sv
module grs_chan_scale #(
   parameter int DW       = 24,
   parameter int GW       = 11,
   parameter int NORM_SH  = 10,
   parameter int BOOST_SH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_en,
   input  logic [DW-1:0] din,
   input  logic [GW-1:0] gain,
   input  logic          boost,
   output logic [DW-1:0] dout
);
   localparam int PW = DW + GW + 1;
   localparam logic signed [PW-1:0] MAXP = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINP = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;
   logic [DW-1:0]        res;

   generate
      if (BOOST_SH > NORM_SH) begin : g_bad
         $error("boost shift must not exceed normal shift");
      end
   endgenerate

   assign prod = PW'($signed(din)) * $signed({1'b0, gain});

   always_comb begin
      if (boost) shifted = prod >>> BOOST_SH;
      else       shifted = prod >>> NORM_SH;
   end

   generate
      if (BOOST_SH == NORM_SH) begin : g_noclip
         assign res = shifted[DW-1:0];
      end else begin : g_clip
         always_comb begin
            if (shifted > MAXP)      res = MAXP[DW-1:0];
            else if (shifted < MINP) res = MINP[DW-1:0];
            else                     res = shifted[DW-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout <= '0;
      else if (smp_en) dout <= res;
   end

   a_r4_zero_gain_silence: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && gain == '0) |=> (dout == '0));
   a_r3_unity_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !boost && gain == GW'(1 << NORM_SH)) |=> (dout == $past(din)));
   a_r6_output_held: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(dout));
endmodule

// File: rtl/gain_ramp_stage.sv
module gain_ramp_stage #(
   parameter int DW       = 24,
   parameter int GW       = 11,
   parameter int NORM_SH  = 10,
   parameter int BOOST_SH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_stb,
   input  logic [DW-1:0] din_l,
   input  logic [DW-1:0] din_r,
   input  logic [GW-1:0] tgt_code,
   input  logic          boost_en,
   output logic [DW-1:0] dout_l,
   output logic [DW-1:0] dout_r,
   output logic [GW-1:0] gain_code
);
   localparam int UNITY = 1 << NORM_SH;
   localparam int NCH   = 2;

   logic [GW-1:0] tgt_q;
   logic          boost_q;
   logic [DW-1:0] ch_in  [NCH];
   logic [DW-1:0] ch_out [NCH];

   generate
      if (DW < 2 || GW < 2) begin : g_bad_w
         $error("widths too small");
      end
   endgenerate

   assign ch_in[0] = din_l;
   assign ch_in[1] = din_r;
   assign dout_l   = ch_out[0];
   assign dout_r   = ch_out[1];

   grs_target_reg #(.GW(GW), .UNITY(UNITY)) u_tgt (
      .clk(clk), .rst_n(rst_n), .code_in(tgt_code), .boost_in(boost_en),
      .tgt_q(tgt_q), .boost_q(boost_q)
   );

   grs_gain_ramp #(.GW(GW), .UNITY(UNITY)) u_ramp (
      .clk(clk), .rst_n(rst_n), .step_en(smp_stb), .tgt(tgt_q), .cur(gain_code)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      grs_chan_scale #(.DW(DW), .GW(GW), .NORM_SH(NORM_SH), .BOOST_SH(BOOST_SH)) u_scale (
         .clk(clk), .rst_n(rst_n), .smp_en(smp_stb), .din(ch_in[c]),
         .gain(gain_code), .boost(boost_q), .dout(ch_out[c])
      );
   end

   a_r8_shared_gain_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && gain_code == '0) |=> (dout_l == '0 && dout_r == '0));
endmodule

// File: tb/gain_ramp_stage_tb.sv
module gain_ramp_stage_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [23:0] din_l = '0, din_r = '0;
   logic [10:0] tgt_code = 11'h400;
   logic        boost_en = 1'b0;
   logic [23:0] dout_l, dout_r;
   logic [10:0] gain_code;

   always #2 clk = ~clk;

   gain_ramp_stage u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .din_l(din_l), .din_r(din_r),
      .tgt_code(tgt_code), .boost_en(boost_en), .dout_l(dout_l), .dout_r(dout_r),
      .gain_code(gain_code)
   );

   typedef struct {
      logic [23:0] l;
      logic [23:0] r;
      logic [10:0] g;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0, n_fail = 0;
   int   m_g = 1024, m_t = 1024;
   bit   m_boost = 0;

   task automatic chk(string tag, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] model(logic [23:0] x, int g, bit b);
      longint p, s;
      p = longint'($signed(x)) * g;
      s = b ? (p >>> 8) : (p >>> 10);
      if (s > 64'sh7FFFFF) s = 64'sh7FFFFF;
      if (s < -64'sh800000) s = -64'sh800000;
      return s[23:0];
   endfunction

   task automatic sample(logic [23:0] l, logic [23:0] r, string tag);
      exp_t e;
      @(negedge clk);
      e.l = model(l, m_g, m_boost);
      e.r = model(r, m_g, m_boost);
      if (m_g < m_t) m_g++;
      else if (m_g > m_t) m_g--;
      e.g = 11'(m_g);
      e.tag = tag;
      q.push_back(e);
      din_l = l; din_r = r; smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
   endtask

   task automatic set_tgt(logic [10:0] c);
      @(negedge clk);
      tgt_code = c;
      m_t = (c > 11'h400) ? 1024 : int'(c);
      @(negedge clk);
   endtask

   task automatic set_boost(bit b);
      @(negedge clk);
      boost_en = b;
      m_boost = b;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      if (smp_stb) begin
         exp_t e;
         #1;
         e = q.pop_front();
         chk({e.tag, " left"}, dout_l, e.l);
         chk({e.tag, " right"}, dout_r, e.r);
         chk({e.tag, " gain"}, gain_code, e.g);
      end
   end

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset gain", gain_code, 11'h400);
      chk("R1 reset left", dout_l, 0);
      chk("R1 reset right", dout_r, 0);
      sample(24'h123456, 24'hF60B0F, "R3 R8 unity");
      sample(24'h7FFFFF, 24'h800000, "R3 unity extremes");
      set_tgt(11'h7FF);
      repeat (3) @(negedge clk);
      chk("R2 no move on large code", gain_code, 11'h400);
      sample(24'h000100, 24'hFFFF00, "R2 stays at ceiling");
      set_tgt(11'h200);
      repeat (4) @(negedge clk);
      chk("R6 no step without strobe", gain_code, 11'h400);
      for (int i = 0; i < 100; i++)
         sample(24'(i * 24'h01F3A7), 24'(-i * 24'h00A5C3 - 1), "R6 R3 ramp down");
      chk("R6 after 100 steps", gain_code, 11'h39C);
      set_tgt(11'h3F0);
      sample(24'h400000, 24'hC00000, "R7 redirect");
      chk("R7 continues from present", gain_code, 11'h39D);
      for (int i = 0; i < 90; i++)
         sample(24'(i * 24'h031111), 24'hFFFFFF, "R7 ramp up");
      sample(24'h000001, 24'hFFFFFF, "R6 hold at target");
      chk("R6 hold at target", gain_code, 11'h3F0);
      set_tgt(11'h400);
      for (int i = 0; i < 16; i++) sample(24'h0, 24'h0, "R6 return");
      set_tgt(11'h0);
      for (int i = 0; i < 1023; i++)
         sample(24'(i * 24'h002B01), 24'hFFFFFD, "R9 sweep");
      chk("R9 one step left", gain_code, 11'h001);
      sample(24'h7FFFFF, 24'h800000, "R9 last step");
      chk("R9 sweep done in 1024", gain_code, 11'h000);
      sample(24'h7FFFFF, 24'h800000, "R4 zero normal");
      set_boost(1'b1);
      sample(24'h7FFFFF, 24'h800000, "R4 zero boost");
      set_tgt(11'h100);
      for (int i = 0; i < 256; i++)
         sample(24'(i * 24'h010203), 24'hFFFFFB, "R5 boost ramp");
      sample(24'h234567, 24'hDCBA99, "R5 boost unity");
      set_tgt(11'h400);
      for (int i = 0; i < 768; i++)
         sample(24'h300000, 24'hD00000, "R5 clip ramp");
      sample(24'h300000, 24'hD00000, "R5 clip both ways");
      sample(24'h001000, 24'hFFF001, "R5 x4 in range");
      set_boost(1'b0);
      set_tgt(11'h200);
      sample(24'hFFFFFF, 24'hFFFFFD, "R3 floor negative");
      repeat (4) @(negedge clk);
      chk("R6 scoreboard drained", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule